// File: doc/BRIEF.md
# Exception control coprocessor

This unit holds the system-control registers that a small 32-bit RISC core consults when it leaves normal program flow. It decides each cycle whether the core must be redirected to the exception handler: at once when a synchronous trap is reported, or at an instruction boundary when an enabled hardware interrupt line is active. When it redirects, it records the return address, the reason code and, for illegal-address faults, the offending address. It also switches the core into kernel mode with interrupts off.

The processor mode and the interrupt enable are kept as a three-deep stack of (mode, enable) pairs: current, previous and old. Taking an exception pushes the stack and the return-from-exception strobe pops it, so one level of nesting keeps its history without help from software. Software reaches the registers through a single move-from / move-to port that is addressed by register number. A privilege check on that port lets user code read the status register and nothing else.

Top module: `sysctl_unit`

## Requirements
- R1: After reset the unit is in kernel mode with interrupts off. The status, cause, exception-PC and bad-address registers all read zero when no interrupt line is active.
- R2: Register numbers are 8 for bad address, 12 for status, 13 for cause and 14 for exception PC. Status bit 0 is the current enable, bit 1 the current mode (1 = user), bits 3:2 the previous pair and bits 5:4 the old pair, each laid out the same way. Status bits 15:10 hold the per-line interrupt masks for lines 5..0. Any other register number reads zero.
- R3: `irq_pending_o` is high exactly when the current enable is 1 and some interrupt line is high with its mask bit set. Cause bits 15:10 show the raw interrupt lines.
- R4: When `insn_done_i` is high and an interrupt is pending, `take_exc_o` is high in that same cycle. After the clock edge, the exception PC holds `next_pc_i` and the cause code (bits 5:2) is 0.
- R5: A trap request raises `take_exc_o` in the same cycle whatever the enable state. After the edge, the exception PC holds `pc_i` and cause bits 5:2 hold `trap_code_i`.
- R6: When a trap and a boundary interrupt coincide, the trap is taken: its code and `pc_i` are recorded.
- R7: Exception entry moves current into previous and previous into old, and sets current to kernel mode with interrupts off. The mask bits are unchanged.
- R8: Return-from-exception in kernel mode copies the previous mode into current with the enable forced to 1, and copies old into previous. Old is unchanged. It is ignored in user mode and in a cycle that takes an exception.
- R9: The bad-address register loads `fault_addr_i` only on a trap with code 4 (illegal-address load) or 5 (illegal-address store). On any other exception it holds its value.
- R10: In kernel mode the status register and exception PC are writable, while writes to cause and bad address are ignored. In user mode a read of status is allowed. Every other access raises `cp_err_o`, reads zero and changes nothing.
- R11: A move-to in a cycle that takes an exception or performs a return is dropped. Exception entry wins over return.
- R12: `exc_vector_o` always equals the `HANDLER_VEC` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_i | input | NIRQ | Hardware interrupt request lines |
| insn_done_i | input | 1 | Instruction boundary; interrupts are sampled here |
| trap_req_i | input | 1 | Synchronous trap request |
| trap_code_i | input | 4 | Exception code of the trap |
| pc_i | input | XLEN | Address of the current instruction |
| next_pc_i | input | XLEN | Address of the next instruction |
| fault_addr_i | input | XLEN | Faulting data or fetch address |
| cp_en_i | input | 1 | Register port access strobe |
| cp_wr_i | input | 1 | 1 = move-to, 0 = move-from |
| cp_addr_i | input | 5 | Register number |
| cp_wdata_i | input | XLEN | Move-to data |
| cp_rdata_o | output | XLEN | Move-from data |
| cp_err_o | output | 1 | Access refused by privilege check |
| eret_i | input | 1 | Return-from-exception strobe |
| take_exc_o | output | 1 | Redirect the core to the handler this cycle |
| exc_vector_o | output | XLEN | Handler address |
| epc_o | output | XLEN | Saved return address |
| user_mode_o | output | 1 | Current mode, 1 = user |
| int_en_o | output | 1 | Current interrupt enable |
| irq_pending_o | output | 1 | Enabled, unmasked interrupt present |

## Verification
Two things can land in one cycle: a synchronous trap and a pending interrupt at an instruction boundary. An exception entry can also coincide with a return strobe and a status move-to. The bench provokes the first by raising an unmasked interrupt with interrupts enabled and presenting a trap together with `insn_done_i`. The recorded return address must be the trapping PC and the cause code must be the trap's. For the second, it fires trap, return and status write together and reads status back: it must show only the push. A return paired with a write must show only the pop.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   localparam int unsigned REGNUM_W = 5;
   localparam int unsigned CODE_W   = 4;
   localparam int unsigned CODE_LSB = 2;
   localparam int unsigned STACK_W  = 6;

   localparam logic [REGNUM_W-1:0] REG_BADADDR = 5'd8;
   localparam logic [REGNUM_W-1:0] REG_STATUS  = 5'd12;
   localparam logic [REGNUM_W-1:0] REG_CAUSE   = 5'd13;
   localparam logic [REGNUM_W-1:0] REG_EPC     = 5'd14;

   localparam logic [CODE_W-1:0] EXC_INT     = 4'd0;
   localparam logic [CODE_W-1:0] EXC_ADDR_LD = 4'd4;
   localparam logic [CODE_W-1:0] EXC_ADDR_ST = 4'd5;
   localparam logic [CODE_W-1:0] EXC_BUS_IF  = 4'd6;
   localparam logic [CODE_W-1:0] EXC_BUS_DA  = 4'd7;
   localparam logic [CODE_W-1:0] EXC_OVF     = 4'd12;
   localparam logic [CODE_W-1:0] EXC_FPU     = 4'd15;

   typedef struct packed {
      logic user;
      logic ie;
   } mode_pair_t;

   typedef struct packed {
      mode_pair_t old_p;
      mode_pair_t prev_p;
      mode_pair_t cur_p;
   } mode_stack_t;

   function automatic logic code_is_addr(input logic [CODE_W-1:0] c);
      return (c == EXC_ADDR_LD) || (c == EXC_ADDR_ST);
   endfunction

endpackage

// File: rtl/sysctl_status.sv
module sysctl_status
   import sysctl_pkg::*;
#(
   parameter int unsigned NIRQ = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push_i,
   input  logic            pop_i,
   input  logic            wr_i,
   input  mode_stack_t     wr_stack_i,
   input  logic [NIRQ-1:0] wr_mask_i,
   output mode_stack_t     stack_o,
   output logic [NIRQ-1:0] mask_o
);

   mode_stack_t     stack_q, stack_d;
   logic [NIRQ-1:0] mask_q;

   always_comb begin
      stack_d = stack_q;
      if (push_i) begin
         stack_d.old_p       = stack_q.prev_p;
         stack_d.prev_p      = stack_q.cur_p;
         stack_d.cur_p.user  = 1'b0;
         stack_d.cur_p.ie    = 1'b0;
      end else if (pop_i) begin
         stack_d.prev_p      = stack_q.old_p;
         stack_d.cur_p.user  = stack_q.prev_p.user;
         stack_d.cur_p.ie    = 1'b1;
      end else if (wr_i) begin
         stack_d = wr_stack_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stack_q <= '0;
         mask_q  <= '0;
      end else begin
         stack_q <= stack_d;
         if (wr_i) mask_q <= wr_mask_i;
      end
   end

   assign stack_o = stack_q;
   assign mask_o  = mask_q;

endmodule

// File: rtl/sysctl_pending.sv
module sysctl_pending #(
   parameter int unsigned NIRQ = 6
) (
   input  logic [NIRQ-1:0] irq_i,
   input  logic [NIRQ-1:0] mask_i,
   input  logic            ie_i,
   output logic            pending_o
);

   logic [NIRQ-1:0] gated;

   for (genvar i = 0; i < NIRQ; i++) begin : g_line
      assign gated[i] = irq_i[i] & mask_i[i];
   end

   assign pending_o = ie_i & (|gated);

endmodule

// File: rtl/sysctl_capture.sv
module sysctl_capture
   import sysctl_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  logic              trap_sel_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic [XLEN-1:0]   pc_i,
   input  logic [XLEN-1:0]   next_pc_i,
   input  logic [XLEN-1:0]   fault_addr_i,
   input  logic              epc_wr_i,
   input  logic [XLEN-1:0]   wdata_i,
   output logic [CODE_W-1:0] code_o,
   output logic [XLEN-1:0]   epc_o,
   output logic [XLEN-1:0]   bad_o
);

   logic [CODE_W-1:0] code_q;
   logic [XLEN-1:0]   epc_q;
   logic [XLEN-1:0]   bad_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= EXC_INT;
         epc_q  <= '0;
         bad_q  <= '0;
      end else if (take_i) begin
         code_q <= trap_sel_i ? code_i : EXC_INT;
         epc_q  <= trap_sel_i ? pc_i : next_pc_i;
         if (trap_sel_i && code_is_addr(code_i)) bad_q <= fault_addr_i;
      end else if (epc_wr_i) begin
         epc_q <= wdata_i;
      end
   end

   assign code_o = code_q;
   assign epc_o  = epc_q;
   assign bad_o  = bad_q;

endmodule

// File: rtl/sysctl_access.sv
module sysctl_access
   import sysctl_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic                en_i,
   input  logic                wr_i,
   input  logic [REGNUM_W-1:0] addr_i,
   input  logic                user_i,
   input  logic [XLEN-1:0]     status_word_i,
   input  logic [XLEN-1:0]     cause_word_i,
   input  logic [XLEN-1:0]     epc_i,
   input  logic [XLEN-1:0]     bad_i,
   output logic                err_o,
   output logic                wr_status_o,
   output logic                wr_epc_o,
   output logic [XLEN-1:0]     rdata_o
);

   logic is_status_rd;
   logic [XLEN-1:0] sel;

   assign is_status_rd = (addr_i == REG_STATUS) && !wr_i;
   assign err_o        = en_i && user_i && !is_status_rd;
   assign wr_status_o  = en_i && wr_i && !user_i && (addr_i == REG_STATUS);
   assign wr_epc_o     = en_i && wr_i && !user_i && (addr_i == REG_EPC);

   always_comb begin
      case (addr_i)
         REG_BADADDR: sel = bad_i;
         REG_STATUS:  sel = status_word_i;
         REG_CAUSE:   sel = cause_word_i;
         REG_EPC:     sel = epc_i;
         default:     sel = '0;
      endcase
   end

   assign rdata_o = (en_i && !wr_i && !err_o) ? sel : '0;

endmodule

// File: rtl/sysctl_unit.sv
module sysctl_unit
   import sysctl_pkg::*;
#(
   parameter int unsigned     XLEN        = 32,
   parameter int unsigned     NIRQ        = 6,
   parameter int unsigned     MASK_LSB    = 10,
   parameter logic [XLEN-1:0] HANDLER_VEC = 32'h8000_0180
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NIRQ-1:0]     irq_i,
   input  logic                insn_done_i,
   input  logic                trap_req_i,
   input  logic [CODE_W-1:0]   trap_code_i,
   input  logic [XLEN-1:0]     pc_i,
   input  logic [XLEN-1:0]     next_pc_i,
   input  logic [XLEN-1:0]     fault_addr_i,
   input  logic                cp_en_i,
   input  logic                cp_wr_i,
   input  logic [REGNUM_W-1:0] cp_addr_i,
   input  logic [XLEN-1:0]     cp_wdata_i,
   output logic [XLEN-1:0]     cp_rdata_o,
   output logic                cp_err_o,
   input  logic                eret_i,
   output logic                take_exc_o,
   output logic [XLEN-1:0]     exc_vector_o,
   output logic [XLEN-1:0]     epc_o,
   output logic                user_mode_o,
   output logic                int_en_o,
   output logic                irq_pending_o
);

   localparam int unsigned CODE_TOP = CODE_LSB + CODE_W;
   localparam int unsigned MASK_TOP = MASK_LSB + NIRQ;

   if (MASK_LSB < STACK_W || MASK_LSB < CODE_TOP || MASK_TOP > XLEN || NIRQ < 1)
   begin : g_cfg_bad
      $error("sysctl_unit: mask field does not fit beside stack and code fields");
   end

   mode_stack_t       stack;
   logic [NIRQ-1:0]   mask;
   logic [CODE_W-1:0] code;
   logic [XLEN-1:0]   epc, bad;
   logic [XLEN-1:0]   status_word, cause_word;
   logic              pending, int_take, take, eret_eff, user;
   logic              acc_wr_status, acc_wr_epc, st_wr, epc_wr;

   assign user = stack.cur_p.user;

   sysctl_pending #(.NIRQ(NIRQ)) u_pend (
      .irq_i     (irq_i),
      .mask_i    (mask),
      .ie_i      (stack.cur_p.ie),
      .pending_o (pending)
   );

   // trap outranks interrupt; entry outranks return; both outrank move-to
   assign int_take = insn_done_i & pending & ~trap_req_i;
   assign take     = trap_req_i | int_take;
   assign eret_eff = eret_i & ~user & ~take;
   assign st_wr    = acc_wr_status & ~take & ~eret_eff;
   assign epc_wr   = acc_wr_epc & ~take & ~eret_eff;

   sysctl_status #(.NIRQ(NIRQ)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (take),
      .pop_i      (eret_eff),
      .wr_i       (st_wr),
      .wr_stack_i (mode_stack_t'(cp_wdata_i[STACK_W-1:0])),
      .wr_mask_i  (cp_wdata_i[MASK_LSB +: NIRQ]),
      .stack_o    (stack),
      .mask_o     (mask)
   );

   sysctl_capture #(.XLEN(XLEN)) u_capture (
      .clk          (clk),
      .rst_n        (rst_n),
      .take_i       (take),
      .trap_sel_i   (trap_req_i),
      .code_i       (trap_code_i),
      .pc_i         (pc_i),
      .next_pc_i    (next_pc_i),
      .fault_addr_i (fault_addr_i),
      .epc_wr_i     (epc_wr),
      .wdata_i      (cp_wdata_i),
      .code_o       (code),
      .epc_o        (epc),
      .bad_o        (bad)
   );

   always_comb begin
      status_word                      = '0;
      status_word[MASK_LSB +: NIRQ]    = mask;
      status_word[STACK_W-1:0]         = stack;
      cause_word                       = '0;
      cause_word[MASK_LSB +: NIRQ]     = irq_i;
      cause_word[CODE_LSB +: CODE_W]   = code;
   end

   sysctl_access #(.XLEN(XLEN)) u_access (
      .en_i          (cp_en_i),
      .wr_i          (cp_wr_i),
      .addr_i        (cp_addr_i),
      .user_i        (user),
      .status_word_i (status_word),
      .cause_word_i  (cause_word),
      .epc_i         (epc),
      .bad_i         (bad),
      .err_o         (cp_err_o),
      .wr_status_o   (acc_wr_status),
      .wr_epc_o      (acc_wr_epc),
      .rdata_o       (cp_rdata_o)
   );

   assign take_exc_o    = take;
   assign exc_vector_o  = HANDLER_VEC;
   assign epc_o         = epc;
   assign user_mode_o   = user;
   assign int_en_o      = stack.cur_p.ie;
   assign irq_pending_o = pending;

endmodule

// File: rtl/sysctl_unit_chk.sv
module sysctl_unit_chk #(
   parameter int unsigned XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            trap_req_i,
   input logic            insn_done_i,
   input logic            eret_i,
   input logic            cp_en_i,
   input logic            cp_wr_i,
   input logic [XLEN-1:0] pc_i,
   input logic [XLEN-1:0] next_pc_i,
   input logic            take_exc_o,
   input logic [XLEN-1:0] epc_o,
   input logic            user_mode_o,
   input logic            int_en_o,
   input logic            irq_pending_o,
   input logic            cp_err_o
);

   // R7
   entry_kernel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_exc_o |=> !user_mode_o && !int_en_o);

   // R5
   trap_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req_i |=> epc_o == $past(pc_i));

   // R4
   int_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_exc_o && !trap_req_i) |=> epc_o == $past(next_pc_i));

   // R4
   int_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_done_i && irq_pending_o) |-> take_exc_o);

   // R3
   pending_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pending_o |-> int_en_o);

   // R8
   eret_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eret_i && !user_mode_o && !take_exc_o) |=> int_en_o);

   // R10
   user_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_en_i && cp_wr_i && user_mode_o && !take_exc_o)
      |=> $stable(user_mode_o) && $stable(int_en_o) && $stable(epc_o));

   // R10
   kernel_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_en_i && !user_mode_o) |-> !cp_err_o);

endmodule

bind sysctl_unit sysctl_unit_chk #(.XLEN(XLEN)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .trap_req_i    (trap_req_i),
   .insn_done_i   (insn_done_i),
   .eret_i        (eret_i),
   .cp_en_i       (cp_en_i),
   .cp_wr_i       (cp_wr_i),
   .pc_i          (pc_i),
   .next_pc_i     (next_pc_i),
   .take_exc_o    (take_exc_o),
   .epc_o         (epc_o),
   .user_mode_o   (user_mode_o),
   .int_en_o      (int_en_o),
   .irq_pending_o (irq_pending_o),
   .cp_err_o      (cp_err_o)
);

// File: tb/sysctl_unit_test.sv
module sysctl_unit_test;

   localparam int unsigned XLEN = 32;
   localparam int unsigned NIRQ = 6;
   localparam logic [31:0] VEC  = 32'h8000_0180;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NIRQ-1:0] irq_i;
   logic            insn_done_i, trap_req_i, cp_en_i, cp_wr_i, eret_i;
   logic [3:0]      trap_code_i;
   logic [31:0]     pc_i, next_pc_i, fault_addr_i, cp_wdata_i;
   logic [4:0]      cp_addr_i;
   logic [31:0]     cp_rdata_o, exc_vector_o, epc_o;
   logic            cp_err_o, take_exc_o, user_mode_o, int_en_o, irq_pending_o;

   int checks = 0;
   int errors = 0;
   bit ended  = 1'b0;

   sysctl_unit #(.XLEN(XLEN), .NIRQ(NIRQ), .MASK_LSB(10), .HANDLER_VEC(VEC)) uut (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .insn_done_i(insn_done_i),
      .trap_req_i(trap_req_i), .trap_code_i(trap_code_i), .pc_i(pc_i),
      .next_pc_i(next_pc_i), .fault_addr_i(fault_addr_i), .cp_en_i(cp_en_i),
      .cp_wr_i(cp_wr_i), .cp_addr_i(cp_addr_i), .cp_wdata_i(cp_wdata_i),
      .cp_rdata_o(cp_rdata_o), .cp_err_o(cp_err_o), .eret_i(eret_i),
      .take_exc_o(take_exc_o), .exc_vector_o(exc_vector_o), .epc_o(epc_o),
      .user_mode_o(user_mode_o), .int_en_o(int_en_o), .irq_pending_o(irq_pending_o)
   );

   always #5 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] sw(input logic [5:0] m, input logic [5:0] s);
      return (32'(m) << 10) | 32'(s);
   endfunction

   function automatic logic [5:0] f_push(input logic [5:0] s);
      return {s[3:0], 2'b00};
   endfunction

   function automatic logic [5:0] f_pop(input logic [5:0] s);
      return {s[5:4], s[5:4], s[3], 1'b1};
   endfunction

   task automatic idle();
      irq_i = '0; insn_done_i = 0; trap_req_i = 0; trap_code_i = 0;
      pc_i = 0; next_pc_i = 0; fault_addr_i = 0; cp_en_i = 0; cp_wr_i = 0;
      cp_addr_i = 0; cp_wdata_i = 0; eret_i = 0;
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic cp_write(input logic [4:0] a, input logic [31:0] d);
      cp_en_i = 1; cp_wr_i = 1; cp_addr_i = a; cp_wdata_i = d;
      tick();
      cp_en_i = 0; cp_wr_i = 0;
   endtask

   task automatic cp_read(input logic [4:0] a, output logic [31:0] d, output logic e);
      cp_en_i = 1; cp_wr_i = 0; cp_addr_i = a;
      #1;
      d = cp_rdata_o; e = cp_err_o;
      cp_en_i = 0;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #2000000;
      if (!ended) begin
         errors++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin : main
      logic [31:0] rd;
      logic        er;
      logic [31:0] exp_bad;
      logic [5:0]  masks [4];
      idle();
      repeat (3) tick();
      rst_n = 1;
      tick();

      // R1 reset state
      chk("R1 user_mode", 32'(user_mode_o), 0);
      chk("R1 int_en", 32'(int_en_o), 0);
      chk("R1 epc", epc_o, 0);
      cp_read(5'd12, rd, er); chk("R1 status", rd, 0);
      cp_read(5'd13, rd, er); chk("R1 cause", rd, 0);
      cp_read(5'd8, rd, er);  chk("R1 badaddr", rd, 0);
      exp_bad = 0;

      // R2 layout, R10 kernel write of status and EPC, unknown number reads 0
      cp_write(5'd12, sw(6'h2D, 6'b110101));
      cp_read(5'd12, rd, er); chk("R2 status readback", rd, sw(6'h2D, 6'b110101));
      chk("R2 mode bit", 32'(user_mode_o), 1'b0);
      chk("R2 enable bit", 32'(int_en_o), 1'b1);
      cp_write(5'd14, 32'h1234_5678);
      chk("R10 epc write", epc_o, 32'h1234_5678);
      cp_write(5'd13, 32'hFFFF_FFFF);
      cp_write(5'd8, 32'hFFFF_FFFF);
      cp_read(5'd13, rd, er); chk("R10 cause write ignored", rd, 0);
      cp_read(5'd8, rd, er);  chk("R10 badaddr write ignored", rd, 0);
      cp_read(5'd3, rd, er);  chk("R2 unknown reg", rd, 0);
      chk("R12 vector", exc_vector_o, VEC);

      // R3 sweep over masks, enable and all line patterns
      masks[0] = 6'h00; masks[1] = 6'h3F; masks[2] = 6'h15; masks[3] = 6'h2A;
      for (int mi = 0; mi < 4; mi++) begin
         for (int ie = 0; ie < 2; ie++) begin
            for (int v = 0; v < 64; v++) begin
               irq_i = '0;
               cp_write(5'd12, sw(masks[mi], 6'(ie)));
               irq_i = 6'(v);
               #1;
               chk("R3 pending", 32'(irq_pending_o),
                   32'((ie == 1) && ((6'(v) & masks[mi]) != 0)));
               cp_read(5'd13, rd, er);
               chk("R3 cause lines", rd, 32'(v) << 10);
            end
         end
      end
      irq_i = '0;

      // R4 interrupt at a boundary from user mode
      cp_write(5'd12, sw(6'h3F, 6'b000011));
      chk("R10 kernel writes user mode", 32'(user_mode_o), 1);
      irq_i = 6'b000010; insn_done_i = 1; pc_i = 32'h100; next_pc_i = 32'h104;
      #1;
      chk("R4 take", 32'(take_exc_o), 1);
      chk("R12 vector on take", exc_vector_o, VEC);
      tick();
      insn_done_i = 0;
      chk("R4 epc next", epc_o, 32'h104);
      chk("R7 kernel after entry", 32'(user_mode_o), 0);
      chk("R7 disabled after entry", 32'(int_en_o), 0);
      cp_read(5'd12, rd, er); chk("R7 stack push", rd, sw(6'h3F, 6'b001100));
      cp_read(5'd13, rd, er); chk("R4 code zero", rd, 32'b10 << 10);
      insn_done_i = 1;
      #1;
      chk("R3 deferred while disabled", 32'(take_exc_o), 0);
      insn_done_i = 0;
      irq_i = '0;

      // R8 return restores user mode and enables
      eret_i = 1; tick(); eret_i = 0;
      chk("R8 user restored", 32'(user_mode_o), 1);
      chk("R8 enabled", 32'(int_en_o), 1);

      // R10 user-mode access rules
      cp_read(5'd12, rd, er);
      chk("R10 user status read", rd, sw(6'h3F, 6'b000011));
      chk("R10 user status read err", 32'(er), 0);
      cp_read(5'd14, rd, er);
      chk("R10 user epc read err", 32'(er), 1);
      chk("R10 user epc read data", rd, 0);
      cp_en_i = 1; cp_wr_i = 1; cp_addr_i = 5'd12; cp_wdata_i = 0;
      #1; chk("R10 user status write err", 32'(cp_err_o), 1);
      tick(); cp_en_i = 0; cp_wr_i = 0;
      cp_write(5'd14, 32'hDEAD_0000);
      chk("R10 user epc write ignored", epc_o, 32'h104);
      cp_read(5'd12, rd, er);
      chk("R10 user status write ignored", rd, sw(6'h3F, 6'b000011));

      // R8 return in user mode ignored
      eret_i = 1; tick(); eret_i = 0;
      cp_read(5'd12, rd, er);
      chk("R8 user eret ignored", rd, sw(6'h3F, 6'b000011));

      // R5 R7 R9 sweep of all codes from user mode
      for (int c = 0; c < 16; c++) begin
         if (user_mode_o == 1'b0) cp_write(5'd12, sw(6'h3F, 6'b000011));
         trap_req_i = 1; trap_code_i = 4'(c);
         pc_i = 32'h2000 + 32'(c) * 4; next_pc_i = pc_i + 4;
         fault_addr_i = 32'hBAD0_0000 + 32'(c);
         #1;
         chk("R5 trap take", 32'(take_exc_o), 1);
         tick();
         trap_req_i = 0;
         if (c == 4 || c == 5) exp_bad = 32'hBAD0_0000 + 32'(c);
         chk("R5 trap epc", epc_o, 32'h2000 + 32'(c) * 4);
         cp_read(5'd13, rd, er); chk("R5 trap code", rd, 32'(c) << 2);
         cp_read(5'd8, rd, er);  chk("R9 badaddr", rd, exp_bad);
         cp_read(5'd12, rd, er); chk("R7 push", rd, sw(6'h3F, f_push(6'b000011)));
      end

      // R7 R8 nesting two levels deep
      cp_write(5'd12, sw(6'h3F, 6'b000011));
      trap_req_i = 1; trap_code_i = 4'd12; tick();
      trap_code_i = 4'd7; tick(); trap_req_i = 0;
      cp_read(5'd12, rd, er);
      chk("R7 nested push", rd, sw(6'h3F, f_push(f_push(6'b000011))));
      eret_i = 1; tick(); eret_i = 0;
      cp_read(5'd12, rd, er);
      chk("R8 first pop", rd, sw(6'h3F, f_pop(f_push(f_push(6'b000011)))));
      chk("R8 first pop kernel", 32'(user_mode_o), 0);
      eret_i = 1; tick(); eret_i = 0;
      chk("R8 second pop user", 32'(user_mode_o), 1);
      cp_read(5'd12, rd, er);
      chk("R8 second pop", rd, sw(6'h3F, f_pop(f_pop(f_push(f_push(6'b000011))))));

      // R6 trap and interrupt in one cycle
      trap_req_i = 1; trap_code_i = 4'd15; tick(); trap_req_i = 0;
      cp_write(5'd12, sw(6'h3F, 6'b000001));
      irq_i = 6'b000100;
      #1; chk("R3 pending enabled", 32'(irq_pending_o), 1);
      insn_done_i = 1; trap_req_i = 1; trap_code_i = 4'd12;
      pc_i = 32'h3000; next_pc_i = 32'h3004;
      tick();
      insn_done_i = 0; trap_req_i = 0;
      chk("R6 trap pc wins", epc_o, 32'h3000);
      cp_read(5'd13, rd, er); chk("R6 trap code wins", rd, (32'b100 << 10) | (32'd12 << 2));
      cp_write(5'd12, sw(6'h3F, 6'b000001));
      insn_done_i = 1; pc_i = 32'h4000; next_pc_i = 32'h4004;
      tick(); insn_done_i = 0;
      chk("R4 interrupt epc", epc_o, 32'h4004);
      cp_read(5'd13, rd, er); chk("R4 interrupt code", rd, 32'b100 << 10);
      irq_i = '0;

      // R11 entry with return and move-to in the same cycle
      cp_write(5'd12, sw(6'h3F, 6'b000001));
      trap_req_i = 1; trap_code_i = 4'd5; pc_i = 32'h5000; fault_addr_i = 32'h0F0F_0000;
      eret_i = 1; cp_en_i = 1; cp_wr_i = 1; cp_addr_i = 5'd12; cp_wdata_i = sw(6'h00, 6'b000011);
      tick();
      trap_req_i = 0; eret_i = 0; cp_en_i = 0; cp_wr_i = 0;
      cp_read(5'd12, rd, er);
      chk("R11 entry beats return and write", rd, sw(6'h3F, f_push(6'b000001)));
      cp_read(5'd8, rd, er); chk("R9 badaddr code 5", rd, 32'h0F0F_0000);
      eret_i = 1; cp_en_i = 1; cp_wr_i = 1; cp_addr_i = 5'd12; cp_wdata_i = 0;
      tick();
      eret_i = 0; cp_en_i = 0; cp_wr_i = 0;
      cp_read(5'd12, rd, er);
      chk("R11 return beats write", rd, sw(6'h3F, f_pop(f_push(6'b000001))));
      eret_i = 1; cp_en_i = 1; cp_wr_i = 1; cp_addr_i = 5'd14; cp_wdata_i = 32'h7777_0000;
      tick();
      eret_i = 0; cp_en_i = 0; cp_wr_i = 0;
      chk("R11 epc write dropped on return", epc_o, 32'h5000);

      ended = 1'b1;
      summary();
   end

endmodule